// File: doc/BRIEF.md
# Bus Controller Register File and Time Base

This block is the processor-facing register set of a MIL-STD-1553B bus controller. A host processor reaches it through a simple synchronous port: one select, one write enable, a 3-bit location number and 16-bit data in each direction. Location 0 depends on direction. A write there sends single-cycle command strobes to an external instruction sequencer. A read there returns the sequencer's 16-bit status word. The other locations hold the setup word, the instruction-list pointer, the message-block pointer (read-only to the host), a free-running time-base counter and the start address of the asynchronous message list.

The sequencer steps or reloads the list pointer as instructions complete, and loads the message pointer. The time-base counter advances at 1, 4, 8 or 32 microseconds per count, and the host may preload it at any time. The block also gates host requests toward the backend memory with an enable input, and passes a backend-mode select straight through to the backend logic.

Top module: `bcr_regfile`

## Requirements
- R1: While `rst_n` is low, every register reads zero and `ctrl_pulse` is zero.
- R2: A host write to location 0 sets `ctrl_pulse` to `cpu_wdata[3:0]` for exactly the following cycle and changes no stored word. Bit 0 starts the list, bit 1 halts it, bit 2 starts the asynchronous list at `async_base`, and bit 3 is passed through. In every other cycle `ctrl_pulse` is zero.
- R3: A host read (`cpu_sel`=1, `cpu_we`=0) of location 0 returns `seq_status`, not the last command written.
- R4: Location 1 (setup) and location 5 (asynchronous list start) are full 16-bit read/write words, also visible on `setup_word` and `async_base`. Locations 6 and 7 read as zero, and writes to them have no effect. With no read in progress, `cpu_rdata` is zero.
- R5: The list pointer (location 2) takes updates in this priority order: host write, then `seq_lp_load` with `seq_lp_value`, then `seq_lp_step`, which adds 1 modulo 2^16.
- R6: The message pointer (location 3) is read-only to the host: a host write to it has no effect. It loads `seq_mp_value` when `seq_mp_load` is high.
- R7: A one-microsecond base tick occurs every CLK_MHZ clock cycles (CLK_MHZ is 12, 16, 20 or 24). The first tick after reset comes on the CLK_MHZ-th rising edge, so at rate code 00 the time counter reads 1 after that edge and 0 before it.
- R8: The time counter (location 4) advances by one every 1, 4, 8 or 32 base ticks, selected by setup bits [1:0] as codes 00, 01, 10 and 11. It holds its value otherwise.
- R9: The time counter wraps from 0xFFFF to 0x0000.
- R10: A host write to location 4 loads the time counter. If an advance falls in the same cycle, the write wins and that advance is lost.
- R11: `be_mem_req` equals `cpu_mem_req` when `cpu_mem_en` is 1 and is 0 otherwise. `cpu_mem_refused` is high when a request arrives while the enable is 0.
- R12: `be_async_mode` follows `async_if_sel` (1 = asynchronous backend, 0 = synchronous).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_sel | input | 1 | Host access strobe |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 3 | Register location |
| cpu_wdata | input | 16 | Host write data |
| cpu_rdata | output | 16 | Host read data |
| ctrl_pulse | output | 4 | Single-cycle command strobes |
| seq_status | input | 16 | Status word from sequencer |
| seq_lp_step | input | 1 | Advance list pointer by one |
| seq_lp_load | input | 1 | Reload list pointer |
| seq_lp_value | input | 16 | Value for list pointer reload |
| seq_mp_load | input | 1 | Load message pointer |
| seq_mp_value | input | 16 | Message block address |
| list_ptr | output | 16 | Current list pointer |
| async_base | output | 16 | Asynchronous list start address |
| setup_word | output | 16 | Setup register contents |
| time_val | output | 16 | Time counter value |
| cpu_mem_req | input | 1 | Host request toward backend memory |
| cpu_mem_en | input | 1 | Host memory access enable |
| be_mem_req | output | 1 | Gated request to backend |
| cpu_mem_refused | output | 1 | Request arrived while disabled |
| async_if_sel | input | 1 | Backend mode select |
| be_async_mode | output | 1 | Backend mode to backend logic |

## Verification
A prescaler out of phase or a rate counter left in a wrong state shows up on `time_val` as a count that lands early or late. At the 1 µs rate this is visible within CLK_MHZ cycles. At the 32 µs rate it can take up to 32·CLK_MHZ cycles. A wrong priority in the list pointer's update shows on `list_ptr` in the cycle right after the collision. A command strobe that sticks or spills into a second cycle shows on `ctrl_pulse` one cycle after the write. The bench therefore compares every output against its own model on every clock, so a divergence is reported in the first cycle it reaches a port.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
  localparam int ADDR_W = 3;
  localparam int RATE_W = 2;
  localparam int RC_W   = 5;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_SETUP = 3'd1;
  localparam logic [ADDR_W-1:0] A_LIST  = 3'd2;
  localparam logic [ADDR_W-1:0] A_MSG   = 3'd3;
  localparam logic [ADDR_W-1:0] A_TIME  = 3'd4;
  localparam logic [ADDR_W-1:0] A_ASYNC = 3'd5;

  // last value of the base-tick counter before a time-counter advance
  function automatic logic [RC_W-1:0] rate_last(input logic [RATE_W-1:0] sel);
    case (sel)
      2'd0:    rate_last = RC_W'(0);
      2'd1:    rate_last = RC_W'(3);
      2'd2:    rate_last = RC_W'(7);
      default: rate_last = RC_W'(31);
    endcase
  endfunction

  // list pointer next value: host write > sequencer load > step
  function automatic logic [15:0] ptr_next(input logic hw, input logic [15:0] hv,
                                           input logic ld, input logic [15:0] lv,
                                           input logic st, input logic [15:0] cur);
    if (hw)      ptr_next = hv;
    else if (ld) ptr_next = lv;
    else if (st) ptr_next = cur + 16'd1;
    else         ptr_next = cur;
  endfunction
endpackage

// File: rtl/bcr_timebase.sv
module bcr_timebase
  import bcr_pkg::*;
#(
  parameter int CLK_MHZ = 12,
  parameter int DW      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              load,
  input  logic [DW-1:0]     load_val,
  output logic              base_tick,
  output logic              time_tick,
  output logic [DW-1:0]     count
);
  localparam int PW = (CLK_MHZ > 1) ? $clog2(CLK_MHZ) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(CLK_MHZ - 1);

  logic [PW-1:0]   pre_q;
  logic [RC_W-1:0] rc_q;

  assign base_tick = (pre_q == PRE_LAST);
  assign time_tick = base_tick && (rc_q >= rate_last(rate_sel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      rc_q  <= '0;
      count <= '0;
    end else begin
      pre_q <= base_tick ? '0 : pre_q + 1'b1;
      if (base_tick) rc_q <= time_tick ? '0 : rc_q + 1'b1;
      if (load)           count <= load_val;
      else if (time_tick) count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/bcr_ptr_reg.sv
module bcr_ptr_reg
  import bcr_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_wr,
  input  logic [DW-1:0] cpu_val,
  input  logic          seq_ld,
  input  logic [DW-1:0] seq_val,
  input  logic          seq_step,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= ptr_next(cpu_wr, cpu_val, seq_ld, seq_val, seq_step, q);
  end
endmodule

// File: rtl/bcr_cpu_port.sv
module bcr_cpu_port
  import bcr_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     status_w,
  input  logic [DW-1:0]     setup_w,
  input  logic [DW-1:0]     list_w,
  input  logic [DW-1:0]     msg_w,
  input  logic [DW-1:0]     time_w,
  input  logic [DW-1:0]     async_w,
  output logic              wr_ctrl,
  output logic              wr_setup,
  output logic              wr_list,
  output logic              wr_time,
  output logic              wr_async,
  output logic [DW-1:0]     rdata
);
  logic wr_any, rd_any;
  assign wr_any = sel && we;
  assign rd_any = sel && !we;

  assign wr_ctrl  = wr_any && (addr == A_CTRL);
  assign wr_setup = wr_any && (addr == A_SETUP);
  assign wr_list  = wr_any && (addr == A_LIST);
  assign wr_time  = wr_any && (addr == A_TIME);
  assign wr_async = wr_any && (addr == A_ASYNC);

  always_comb begin
    rdata = '0;
    if (rd_any) begin
      case (addr)
        A_CTRL:  rdata = status_w;
        A_SETUP: rdata = setup_w;
        A_LIST:  rdata = list_w;
        A_MSG:   rdata = msg_w;
        A_TIME:  rdata = time_w;
        A_ASYNC: rdata = async_w;
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/bcr_regfile.sv
module bcr_regfile
  import bcr_pkg::*;
#(
  parameter int CLK_MHZ = 12,
  parameter int DW      = 16,
  parameter int CW      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_sel,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DW-1:0]     cpu_wdata,
  output logic [DW-1:0]     cpu_rdata,
  output logic [CW-1:0]     ctrl_pulse,
  input  logic [DW-1:0]     seq_status,
  input  logic              seq_lp_step,
  input  logic              seq_lp_load,
  input  logic [DW-1:0]     seq_lp_value,
  input  logic              seq_mp_load,
  input  logic [DW-1:0]     seq_mp_value,
  output logic [DW-1:0]     list_ptr,
  output logic [DW-1:0]     async_base,
  output logic [DW-1:0]     setup_word,
  output logic [DW-1:0]     time_val,
  input  logic              cpu_mem_req,
  input  logic              cpu_mem_en,
  output logic              be_mem_req,
  output logic              cpu_mem_refused,
  input  logic              async_if_sel,
  output logic              be_async_mode
);
  // named internal events (also observed by the checker)
  logic          wr_ctrl, wr_setup, wr_list, wr_time, wr_async;
  logic          base_tick, time_tick;
  logic [DW-1:0] msg_q;
  logic [CW-1:0] pulse_q;

  bcr_cpu_port #(.DW(DW)) u_port (
    .sel(cpu_sel), .we(cpu_we), .addr(cpu_addr),
    .status_w(seq_status), .setup_w(setup_word), .list_w(list_ptr),
    .msg_w(msg_q), .time_w(time_val), .async_w(async_base),
    .wr_ctrl(wr_ctrl), .wr_setup(wr_setup), .wr_list(wr_list),
    .wr_time(wr_time), .wr_async(wr_async), .rdata(cpu_rdata)
  );

  bcr_ptr_reg #(.DW(DW)) u_list (
    .clk(clk), .rst_n(rst_n), .cpu_wr(wr_list), .cpu_val(cpu_wdata),
    .seq_ld(seq_lp_load), .seq_val(seq_lp_value), .seq_step(seq_lp_step),
    .q(list_ptr)
  );

  bcr_ptr_reg #(.DW(DW)) u_msg (
    .clk(clk), .rst_n(rst_n), .cpu_wr(1'b0), .cpu_val('0),
    .seq_ld(seq_mp_load), .seq_val(seq_mp_value), .seq_step(1'b0),
    .q(msg_q)
  );

  bcr_ptr_reg #(.DW(DW)) u_setup (
    .clk(clk), .rst_n(rst_n), .cpu_wr(wr_setup), .cpu_val(cpu_wdata),
    .seq_ld(1'b0), .seq_val('0), .seq_step(1'b0),
    .q(setup_word)
  );

  bcr_ptr_reg #(.DW(DW)) u_async (
    .clk(clk), .rst_n(rst_n), .cpu_wr(wr_async), .cpu_val(cpu_wdata),
    .seq_ld(1'b0), .seq_val('0), .seq_step(1'b0),
    .q(async_base)
  );

  bcr_timebase #(.CLK_MHZ(CLK_MHZ), .DW(DW)) u_tb (
    .clk(clk), .rst_n(rst_n), .rate_sel(setup_word[RATE_W-1:0]),
    .load(wr_time), .load_val(cpu_wdata),
    .base_tick(base_tick), .time_tick(time_tick), .count(time_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= '0;
    else        pulse_q <= wr_ctrl ? cpu_wdata[CW-1:0] : '0;
  end
  assign ctrl_pulse = pulse_q;

  assign be_mem_req      = cpu_mem_req && cpu_mem_en;
  assign cpu_mem_refused = cpu_mem_req && !cpu_mem_en;
  assign be_async_mode   = async_if_sel;
endmodule

// File: rtl/bcr_regfile_chk.sv
module bcr_regfile_chk
  import bcr_pkg::*;
#(
  parameter int CLK_MHZ = 12,
  parameter int DW      = 16,
  parameter int CW      = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_sel,
  input logic              cpu_we,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [DW-1:0]     cpu_wdata,
  input logic [CW-1:0]     ctrl_pulse,
  input logic              seq_mp_load,
  input logic [DW-1:0]     msg_q,
  input logic              wr_list,
  input logic [DW-1:0]     list_ptr,
  input logic              wr_time,
  input logic              time_tick,
  input logic              base_tick,
  input logic [DW-1:0]     time_val,
  input logic              cpu_mem_en,
  input logic              be_mem_req
);
  logic [15:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         gap_q <= '0;
    else if (base_tick) gap_q <= '0;
    else                gap_q <= gap_q + 16'd1;
  end

  a_r2_pulse_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_sel && cpu_we && cpu_addr == A_CTRL) |=> ctrl_pulse == '0);

  a_r5_host_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_list |=> list_ptr == $past(cpu_wdata));

  a_r6_msg_held: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_mp_load |=> $stable(msg_q));

  a_r7_base_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    base_tick |-> gap_q == 16'(CLK_MHZ - 1));

  a_r8_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (!time_tick && !wr_time) |=> $stable(time_val));

  a_r9_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (time_tick && !wr_time && time_val == '1) |=> time_val == '0);

  a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_time |=> time_val == $past(cpu_wdata));

  a_r11_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_mem_en |-> !be_mem_req);
endmodule

bind bcr_regfile bcr_regfile_chk #(.CLK_MHZ(CLK_MHZ), .DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_we(cpu_we),
  .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .ctrl_pulse(ctrl_pulse),
  .seq_mp_load(seq_mp_load), .msg_q(msg_q), .wr_list(wr_list),
  .list_ptr(list_ptr), .wr_time(wr_time), .time_tick(time_tick),
  .base_tick(base_tick), .time_val(time_val), .cpu_mem_en(cpu_mem_en),
  .be_mem_req(be_mem_req)
);

// File: tb/sim_bcr_regfile.sv
module sim_bcr_regfile;
  localparam int CLK_PERIOD = 10;
  localparam int MHZ = 12;

  logic clk = 0, rst_n = 0;
  logic cpu_sel = 0, cpu_we = 0;
  logic [2:0] cpu_addr = 0;
  logic [15:0] cpu_wdata = 0, seq_status = 0, seq_lp_value = 0, seq_mp_value = 0;
  logic seq_lp_step = 0, seq_lp_load = 0, seq_mp_load = 0;
  logic cpu_mem_req = 0, cpu_mem_en = 0, async_if_sel = 0;
  logic [15:0] cpu_rdata, list_ptr, async_base, setup_word, time_val;
  logic [3:0] ctrl_pulse;
  logic be_mem_req, cpu_mem_refused, be_async_mode;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcr_regfile #(.CLK_MHZ(MHZ)) u0 (.*);

  // ---- behavioural reference model ----
  int m_pre, m_rc, m_time, m_setup, m_lp, m_mp, m_ap, m_pulse;

  function automatic int period_of(int code);
    case (code & 3)
      0: return 1;
      1: return 4;
      2: return 8;
      default: return 32;
    endcase
  endfunction

  function automatic int model_read(int a);
    if (!(cpu_sel && !cpu_we)) return 0;
    case (a)
      0: return seq_status;
      1: return m_setup;
      2: return m_lp;
      3: return m_mp;
      4: return m_time;
      5: return m_ap;
      default: return 0;
    endcase
  endfunction

  function automatic string read_tag(int a);
    case (a)
      0: return "R3";
      2: return "R5";
      3: return "R6";
      4: return "R8";
      default: return "R4";
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pre = 0; m_rc = 0; m_time = 0; m_setup = 0;
      m_lp = 0; m_mp = 0; m_ap = 0; m_pulse = 0;
    end else begin
      bit wr, tk, base;
      wr = cpu_sel && cpu_we;
      tk = 0;
      base = (m_pre == MHZ - 1);
      if (base) begin
        if (m_rc >= period_of(m_setup) - 1) begin m_rc = 0; tk = 1; end
        else m_rc = m_rc + 1;
      end
      m_pre = base ? 0 : m_pre + 1;
      if (wr && cpu_addr == 4) m_time = cpu_wdata;
      else if (tk)             m_time = (m_time + 1) % 65536;
      m_pulse = (wr && cpu_addr == 0) ? (cpu_wdata & 15) : 0;
      if (wr && cpu_addr == 1) m_setup = cpu_wdata;
      if (wr && cpu_addr == 5) m_ap = cpu_wdata;
      if (wr && cpu_addr == 2) m_lp = cpu_wdata;
      else if (seq_lp_load)    m_lp = seq_lp_value;
      else if (seq_lp_step)    m_lp = (m_lp + 1) % 65536;
      if (seq_mp_load) m_mp = seq_mp_value;
    end
    #2;
    if (!done) begin
      check("R2", ctrl_pulse, m_pulse);
      check("R5", list_ptr, m_lp);
      check("R8", time_val, m_time);
      check("R4", setup_word, m_setup);
      check("R4", async_base, m_ap);
      check(read_tag(cpu_addr), cpu_rdata, model_read(cpu_addr));
      check("R11", be_mem_req, cpu_mem_req && cpu_mem_en);
      check("R11", cpu_mem_refused, cpu_mem_req && !cpu_mem_en);
      check("R12", be_async_mode, async_if_sel);
    end
  end

  // ---- stimulus helpers ----
  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_write(int a, int d);
    cpu_sel = 1; cpu_we = 1; cpu_addr = 3'(a); cpu_wdata = 16'(d);
    @(negedge clk);
    cpu_we = 0; cpu_sel = 0;
  endtask

  task automatic host_read(int a, output int d);
    cpu_sel = 1; cpu_we = 0; cpu_addr = 3'(a);
    #1 d = cpu_rdata;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected finish");
    finish_run();
  end

  initial begin
    int d, t0;
    cyc(3);
    check("R1", time_val, 0);
    check("R1", list_ptr, 0);
    check("R1", ctrl_pulse, 0);
    rst_n = 1;

    // R7: first base tick on the MHZ-th edge
    cyc(MHZ - 1);
    check("R7", time_val, 0);
    cyc(1);
    check("R7", time_val, 1);

    // R2 / R3: command strobes and status read
    seq_status = 16'hA5C3;
    host_write(0, 16'hFFF5);
    check("R2", ctrl_pulse, 4'h5);
    cyc(1);
    check("R2", ctrl_pulse, 0);
    host_read(0, d);
    check("R3", d, 16'hA5C3);
    cyc(1);

    // R4: read/write words and unused locations
    host_write(1, 16'h1230);
    host_write(5, 16'hBEEF);
    host_write(6, 16'h1111);
    host_write(7, 16'h2222);
    host_read(1, d); check("R4", d, 16'h1230);
    host_read(5, d); check("R4", d, 16'hBEEF);
    check("R4", async_base, 16'hBEEF);
    host_read(6, d); check("R4", d, 0);
    host_read(7, d); check("R4", d, 0);
    cyc(1);
    cpu_sel = 0; #1 check("R4", cpu_rdata, 0);

    // R5: list pointer priority
    host_write(2, 16'h0100);
    seq_lp_step = 1; cyc(3); seq_lp_step = 0;
    check("R5", list_ptr, 16'h0103);
    seq_lp_load = 1; seq_lp_step = 1; seq_lp_value = 16'h0200;
    cyc(1);
    check("R5", list_ptr, 16'h0200);
    seq_lp_value = 16'h0250;
    host_write(2, 16'h0300);
    seq_lp_load = 0; seq_lp_step = 0;
    check("R5", list_ptr, 16'h0300);
    host_write(2, 16'hFFFF);
    seq_lp_step = 1; cyc(1); seq_lp_step = 0;
    check("R5", list_ptr, 16'h0000);

    // R6: message pointer read-only
    host_write(3, 16'h7777);
    host_read(3, d); check("R6", d, 0);
    cyc(1);
    seq_mp_value = 16'h4321; seq_mp_load = 1; cyc(1); seq_mp_load = 0;
    host_read(3, d); check("R6", d, 16'h4321);
    cyc(1);

    // R10: write collides with a tick
    while (m_pre != MHZ - 1) cyc(1);
    host_write(4, 16'h1234);
    check("R10", time_val, 16'h1234);

    // R9: wrap
    host_write(4, 16'hFFFE);
    cyc(MHZ * 3);
    check("R9", time_val, 16'h0001);

    // R8: each rate gives four advances in four periods
    for (int code = 1; code < 4; code++) begin
      host_write(1, code);
      cyc(400);
      t0 = time_val;
      cyc(MHZ * period_of(code) * 4);
      check("R8", (time_val - t0) & 16'hFFFF, 4);
    end

    // R11 / R12
    cpu_mem_req = 1; cpu_mem_en = 0; #1;
    check("R11", be_mem_req, 0); check("R11", cpu_mem_refused, 1);
    cyc(1);
    cpu_mem_en = 1; #1;
    check("R11", be_mem_req, 1); check("R11", cpu_mem_refused, 0);
    cyc(1);
    async_if_sel = 1; #1 check("R12", be_async_mode, 1);
    cyc(1);
    async_if_sel = 0; #1 check("R12", be_async_mode, 0);
    cyc(2);
    finish_run();
  end
endmodule